// File: doc/BRIEF.md
# Capture/Compare Timer with Fast-Clear Flags

This block is a 16-bit free-running timer. A power-of-two prescaler sets how fast it counts. Four channels sit on the counter, and each one is set independently either to latch the count on a rising input edge (capture) or to flag the moment the count reaches a programmed value (compare). A separate 16-bit pulse accumulator counts rising edges on its own input. Every event source has a sticky flag bit, and every flag has an interrupt enable. Compare events also toggle a per-channel output pin.

Software reaches the block through a simple register bus: an address, read and write strobes, two byte enables and 16-bit data. Read data is combinational from the address, so a word read of the counter returns both bytes from the same cycle. Flags can be cleared in one of two ways, chosen by a control bit. In the normal mode, software writes ones to the flag register. In the fast mode, flags clear as a side effect of touching the data register they belong to, which saves a bus access per event.

Register map (word addresses): 0 control (bit 7 run, bit 4 fast-clear), 1 config (bits 2:0 prescale exponent N, bit 8+i channel i compare mode), 2 interrupt enables (same bit positions as the flags), 3 flags (bits 3:0 channels, bit 4 counter wrap, bit 5 accumulator wrap, bit 6 accumulator edge), 4 counter, 5 accumulator, 8+i channel i value. Byte enable bit 0 selects data bits 7:0 and bit 1 selects bits 15:8.

Top module: `gpt_timer`

## Requirements
- R1: After reset, the control register, the counter, the flags and all pin and interrupt outputs are zero.
- R2: With control bit 7 clear, the counter and prescaler hold. Control reads back only bits 7 and 4; every other bit reads zero.
- R3: With run set, the counter advances by one every 2^N clock cycles, where N is config bits 2:0.
- R4: A write to the counter takes effect only while test_mode is high and is otherwise ignored. Byte enables select which bytes are written.
- R5: After a counter write, the written value lasts 2^N+1 cycles of counting before the first increment.
- R6: Flag bit 4 sets when the counter wraps from 0xFFFF to 0x0000.
- R7: A channel in capture mode (config bit 8+i = 0), while running, latches the counter into its value register on a rising edge of cap_in[i] and sets flag bit i.
- R8: A channel in compare mode (config bit 8+i = 1), when the counter steps to its value register, sets flag bit i and toggles cmp_out[i].
- R9: With fast-clear off, writing 1 to a flag bit (byte 0 enabled) clears it. With fast-clear on, such writes have no effect.
- R10: With fast-clear on, reading a capture-mode channel register, or writing a compare-mode channel register, clears that channel's flag.
- R11: With fast-clear on, any read or write of the counter register clears flag bit 4.
- R12: While running, the accumulator counts rising edges of acc_in and sets flag bit 6 on each one; a wrap from 0xFFFF sets flag bit 5. With fast-clear on, any access to the accumulator clears both bits.
- R13: When a flag-setting event and a clearing access fall in the same cycle, the flag ends up set.
- R14: Each interrupt output is the AND of its flag(s) and enable bit(s). irq_acc covers flag bits 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode | input | 1 | Allows counter writes |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 2 | Byte enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| cap_in | input | 4 | Capture inputs, one per channel |
| acc_in | input | 1 | Pulse accumulator input |
| cmp_out | output | 4 | Compare toggle pins |
| irq_ch | output | 4 | Channel interrupts |
| irq_ovf | output | 1 | Counter wrap interrupt |
| irq_acc | output | 1 | Accumulator interrupt |

## Verification
The counting function is driven through a table of prescale exponents and wait lengths. These include entries that differ by a single cycle at N=7, which separates a correct extra resync cycle from a missing one. The boundary entries at N=0 and N=1 separate a wrong mask from a wrong divider. The clear paths are tried under both fast-clear settings and with the run bit both set and clear, so that a write-one-to-clear path active in fast mode can be told apart from a correct one. A capture edge that coincides with a clearing read shows whether set wins over clear. Compare-pin timing is sampled one cycle before and one cycle after the match edge.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int BUS_W    = 16;
  localparam int REG_CTRL = 0;
  localparam int REG_CFG  = 1;
  localparam int REG_IEN  = 2;
  localparam int REG_FLAG = 3;
  localparam int REG_CNT  = 4;
  localparam int REG_ACC  = 5;
  localparam int REG_CH0  = 8;
  localparam int CTRL_RUN_BIT  = 7;
  localparam int CTRL_FAST_BIT = 4;

  // Byte-lane merge for partial writes.
  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old_v,
                                                  input logic [BUS_W-1:0] new_v,
                                                  input logic [1:0] be);
    logic [BUS_W-1:0] r;
    r[7:0]  = be[0] ? new_v[7:0]  : old_v[7:0];
    r[15:8] = be[1] ? new_v[15:8] : old_v[15:8];
    return r;
  endfunction
endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale #(
  parameter int PN_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PN_W-1:0] n_sel,
  input  logic            resync,
  output logic            tick
);
  localparam int PW = (1 << PN_W) - 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask;
  logic          hold_q;

  always_comb begin
    for (int i = 0; i < PW; i++) mask[i] = (i < int'(n_sel));
  end

  assign tick = run && !hold_q && ((pre_q & mask) == mask);

  // A counter write restarts the divider and swallows one tick slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      hold_q <= 1'b0;
    end else if (resync) begin
      pre_q  <= '0;
      hold_q <= 1'b1;
    end else if (run) begin
      if (hold_q) hold_q <= 1'b0;
      else        pre_q  <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel import gpt_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             mode_cmp,
  input  logic             cap_in,
  input  logic [BUS_W-1:0] cnt_q,
  input  logic             step,
  input  logic [BUS_W-1:0] cnt_nxt,
  input  logic             wr_en,
  input  logic [1:0]       be,
  input  logic [BUS_W-1:0] wdata,
  output logic             set_evt,
  output logic [BUS_W-1:0] val_q,
  output logic             pin_q
);
  logic prev_q;
  logic rise;

  assign rise    = cap_in && !prev_q;
  assign set_evt = run && (mode_cmp ? (step && (cnt_nxt == val_q)) : rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      val_q  <= '0;
      pin_q  <= 1'b0;
    end else begin
      prev_q <= cap_in;
      if (!mode_cmp && set_evt) val_q <= cnt_q;
      else if (wr_en)           val_q <= lane_merge(val_q, wdata, be);
      if (mode_cmp && set_evt)  pin_q <= !pin_q;
    end
  end
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer import gpt_pkg::*; #(
  parameter int NCH  = 4,
  parameter int AW   = 4,
  parameter int PN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_be,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [NCH-1:0]   cap_in,
  input  logic             acc_in,
  output logic [NCH-1:0]   cmp_out,
  output logic [NCH-1:0]   irq_ch,
  output logic             irq_ovf,
  output logic             irq_acc
);
  localparam int NFLG  = NCH + 3;
  localparam int F_TOF = NCH;
  localparam int F_AOV = NCH + 1;
  localparam int F_AEV = NCH + 2;
  localparam logic [AW-1:0] A_CTRL = AW'(REG_CTRL);
  localparam logic [AW-1:0] A_CFG  = AW'(REG_CFG);
  localparam logic [AW-1:0] A_IEN  = AW'(REG_IEN);
  localparam logic [AW-1:0] A_FLAG = AW'(REG_FLAG);
  localparam logic [AW-1:0] A_CNT  = AW'(REG_CNT);
  localparam logic [AW-1:0] A_ACC  = AW'(REG_ACC);

  logic             en_q, fast_q, acc_prev_q;
  logic [PN_W-1:0]  n_q;
  logic [NCH-1:0]   mode_q, ch_set, ch_hit;
  logic [NFLG-1:0]  ien_q, flag_q, flag_set, flag_clr;
  logic [BUS_W-1:0] cnt_q, cnt_nxt, acc_q;
  logic [BUS_W-1:0] ch_val [NCH];
  logic             tick, cnt_wr, cnt_touch, acc_touch, acc_rise;

  assign cnt_wr    = bus_wr && test_mode && (bus_addr == A_CNT);
  assign cnt_touch = (bus_rd || bus_wr) && (bus_addr == A_CNT);
  assign acc_touch = (bus_rd || bus_wr) && (bus_addr == A_ACC);
  assign cnt_nxt   = cnt_q + 1'b1;
  assign acc_rise  = en_q && acc_in && !acc_prev_q;

  gpt_prescale #(.PN_W(PN_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(en_q), .n_sel(n_q), .resync(cnt_wr), .tick(tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_hit[g] = (bus_addr == AW'(REG_CH0 + g));
    gpt_channel u_ch (
      .clk(clk), .rst_n(rst_n), .run(en_q), .mode_cmp(mode_q[g]), .cap_in(cap_in[g]),
      .cnt_q(cnt_q), .step(tick), .cnt_nxt(cnt_nxt),
      .wr_en(bus_wr && ch_hit[g]), .be(bus_be), .wdata(bus_wdata),
      .set_evt(ch_set[g]), .val_q(ch_val[g]), .pin_q(cmp_out[g])
    );
  end

  // Control, config, enables, counter and accumulator storage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      fast_q     <= 1'b0;
      n_q        <= '0;
      mode_q     <= '0;
      ien_q      <= '0;
      cnt_q      <= '0;
      acc_q      <= '0;
      acc_prev_q <= 1'b0;
    end else begin
      acc_prev_q <= acc_in;
      if (bus_wr && bus_addr == A_CTRL && bus_be[0]) begin
        en_q   <= bus_wdata[CTRL_RUN_BIT];
        fast_q <= bus_wdata[CTRL_FAST_BIT];
      end
      if (bus_wr && bus_addr == A_CFG && bus_be[0]) n_q    <= bus_wdata[PN_W-1:0];
      if (bus_wr && bus_addr == A_CFG && bus_be[1]) mode_q <= bus_wdata[8 +: NCH];
      if (bus_wr && bus_addr == A_IEN && bus_be[0]) ien_q  <= bus_wdata[NFLG-1:0];
      if (cnt_wr)    cnt_q <= lane_merge(cnt_q, bus_wdata, bus_be);
      else if (tick) cnt_q <= cnt_nxt;
      if (bus_wr && bus_addr == A_ACC) acc_q <= lane_merge(acc_q, bus_wdata, bus_be);
      else if (acc_rise)               acc_q <= acc_q + 1'b1;
    end
  end

  // Flag events and the two clearing schemes.
  always_comb begin
    flag_set             = '0;
    flag_set[NCH-1:0]    = ch_set;
    flag_set[F_TOF]      = tick && (&cnt_q);
    flag_set[F_AOV]      = acc_rise && (&acc_q);
    flag_set[F_AEV]      = acc_rise;
    flag_clr             = '0;
    if (fast_q) begin
      for (int i = 0; i < NCH; i++)
        flag_clr[i] = ch_hit[i] && ((bus_rd && !mode_q[i]) || (bus_wr && mode_q[i]));
      flag_clr[F_TOF] = cnt_touch;
      flag_clr[F_AOV] = acc_touch;
      flag_clr[F_AEV] = acc_touch;
    end else if (bus_wr && bus_addr == A_FLAG && bus_be[0]) begin
      flag_clr = bus_wdata[NFLG-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[CTRL_RUN_BIT]  = en_q;
        bus_rdata[CTRL_FAST_BIT] = fast_q;
      end
      A_CFG: begin
        bus_rdata[PN_W-1:0] = n_q;
        bus_rdata[8 +: NCH] = mode_q;
      end
      A_IEN:  bus_rdata[NFLG-1:0] = ien_q;
      A_FLAG: bus_rdata[NFLG-1:0] = flag_q;
      A_CNT:  bus_rdata = cnt_q;
      A_ACC:  bus_rdata = acc_q;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (bus_addr == AW'(REG_CH0 + i)) bus_rdata = ch_val[i];
      end
    endcase
  end

  assign irq_ch  = flag_q[NCH-1:0] & ien_q[NCH-1:0];
  assign irq_ovf = flag_q[F_TOF] & ien_q[F_TOF];
  assign irq_acc = |(flag_q[F_AEV:F_AOV] & ien_q[F_AEV:F_AOV]);
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           test_mode,
  input logic           en_q,
  input logic           fast_q,
  input logic           tick,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [AW-1:0]  bus_addr,
  input logic [15:0]    bus_rdata,
  input logic [15:0]    cnt_q,
  input logic [NCH+2:0] flag_q,
  input logic [NCH-1:0] mode_q,
  input logic [NCH-1:0] cap_in
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CNT  = AW'(4);

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_CTRL) |-> (bus_rdata[15:8] == 8'h00 && bus_rdata[6:5] == 2'b00 && bus_rdata[3:0] == 4'h0)); // R2
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !(bus_wr && bus_addr == A_CNT)) |=> $stable(cnt_q)); // R2
  AST_NO_NORMAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !tick) |=> $stable(cnt_q)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(test_mode && bus_wr && bus_addr == A_CNT)) |=> (cnt_q == 16'($past(cnt_q) + 16'd1))); // R3
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&cnt_q)) |=> flag_q[NCH]); // R6
  AST_WRAP_FAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_q && (bus_rd || bus_wr) && bus_addr == A_CNT && !(tick && (&cnt_q))) |=> !flag_q[NCH]); // R11

  for (genvar g = 0; g < NCH; g++) begin : g_cap
    AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !mode_q[g] && $rose(cap_in[g])) |=> flag_q[g]); // R13
  end
endmodule

bind gpt_timer gpt_timer_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .en_q(en_q), .fast_q(fast_q),
  .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .cnt_q(cnt_q), .flag_q(flag_q), .mode_q(mode_q), .cap_in(cap_in)
);

// File: tb/tb_gpt_timer.sv
`timescale 1ns/1ps
module tb_gpt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_mode = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_be = 2'b11;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  cap_in = '0;
  logic        acc_in = 1'b0;
  logic [3:0]  cmp_out, irq_ch;
  logic        irq_ovf, irq_acc;
  int n_chk = 0, n_bad = 0;
  logic [15:0] rd, rd2;

  // {N, wait cycles after enable, expected count}
  localparam logic [31:0] PRE_VEC [6] = '{32'h00000A09, 32'h01000A04, 32'h02000D03,
                                          32'h03001102, 32'h07008101, 32'h07008000};

  gpt_timer dut (.clk(clk), .rst_n(rst_n), .test_mode(test_mode), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cap_in(cap_in), .acc_in(acc_in), .cmp_out(cmp_out),
    .irq_ch(irq_ch), .irq_ovf(irq_ovf), .irq_acc(irq_acc));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b11;
  endtask

  task automatic rdr(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cnt_load(input logic [15:0] v);
    test_mode = 1'b1; wr(4'd4, v); test_mode = 1'b0;
  endtask

  task automatic pulse_acc();
    acc_in = 1'b1; @(negedge clk); acc_in = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdr(4'd0, rd); check("R1 ctrl", rd, 0);
    rdr(4'd4, rd); check("R1 count", rd, 0);
    rdr(4'd3, rd); check("R1 flags", rd, 0);
    check("R1 outputs", {cmp_out, irq_ch, irq_ovf, irq_acc}, 0);

    // R3 / R5 prescaler table
    for (int i = 0; i < 6; i++) begin
      wr(4'd0, 16'h0000);
      wr(4'd1, {8'h00, PRE_VEC[i][31:24]});
      cnt_load(16'h0000);
      wr(4'd0, 16'h0080);
      repeat (int'(PRE_VEC[i][23:8])) @(negedge clk);
      rdr(4'd4, rd);
      check(i >= 4 ? "R5 first count after write" : "R3 prescaled count", rd, {8'h00, PRE_VEC[i][7:0]});
    end

    // R2 stop holds, reserved bits read zero
    wr(4'd0, 16'h0000);
    rdr(4'd4, rd); repeat (40) @(negedge clk); rdr(4'd4, rd2);
    check("R2 stopped counter holds", rd2, rd);
    wr(4'd0, 16'h00FF); wr(4'd0, 16'h0000);
    wr(4'd0, 16'h00FF); rdr(4'd0, rd); check("R2 ctrl readback", rd, 16'h0090);
    wr(4'd0, 16'h0000);

    // R4 normal-mode write ignored, byte lanes in test mode
    rdr(4'd4, rd); wr(4'd4, 16'h1234); rdr(4'd4, rd2);
    check("R4 write ignored", rd2, rd);
    cnt_load(16'h0000);
    test_mode = 1'b1; wr(4'd4, 16'hABCD, 2'b10); test_mode = 1'b0;
    rdr(4'd4, rd); check("R4 high byte only", rd, 16'hAB00);

    // R6 / R14 wrap flag and interrupt
    wr(4'd1, 16'h0000); wr(4'd2, 16'h0010);
    cnt_load(16'hFFFE); wr(4'd0, 16'h0080);
    repeat (5) @(negedge clk); wr(4'd0, 16'h0000);
    rdr(4'd3, rd); check("R6 wrap flag", rd[4], 1);
    check("R14 irq_ovf", irq_ovf, 1);
    wr(4'd3, 16'h0010); rdr(4'd3, rd); check("R9 w1c clears", rd[4], 0);
    check("R14 irq_ovf low", irq_ovf, 0);

    // R9 fast mode ignores w1c; R11 counter access clears
    cnt_load(16'hFFFF); wr(4'd0, 16'h0090);
    repeat (3) @(negedge clk); wr(4'd0, 16'h0010);
    wr(4'd3, 16'h0010); rdr(4'd3, rd); check("R9 w1c ignored in fast mode", rd[4], 1);
    rdr(4'd4, rd2); rdr(4'd3, rd); check("R11 count access clears", rd[4], 0);

    // R7 capture
    wr(4'd0, 16'h0000); wr(4'd1, 16'h0007);
    cnt_load(16'h0500); wr(4'd0, 16'h0080);
    cap_in = 4'b0100; @(negedge clk); cap_in = 4'b0000;
    rdr(4'd10, rd); check("R7 captured value", rd, 16'h0500);
    rdr(4'd3, rd); check("R7 channel flags", rd[3:0], 4'b0100);

    // R10 capture read clears in fast mode
    wr(4'd0, 16'h0090);
    rdr(4'd10, rd); rdr(4'd3, rd); check("R10 capture read clears", rd[2], 0);

    // R13 capture edge coincides with clearing read
    bus_addr = 4'd8; bus_rd = 1'b1; cap_in = 4'b0001;
    @(negedge clk); bus_rd = 1'b0; cap_in = 4'b0000;
    rdr(4'd3, rd); check("R13 set wins", rd[0], 1);

    // R8 compare match
    wr(4'd0, 16'h0010); wr(4'd1, 16'h0200);
    wr(4'd9, 16'h0010); cnt_load(16'h000C); wr(4'd0, 16'h0090);
    repeat (4) @(negedge clk); check("R8 pin before match", cmp_out[1], 0);
    repeat (2) @(negedge clk); check("R8 pin toggled", cmp_out[1], 1);
    wr(4'd0, 16'h0010);
    rdr(4'd3, rd); check("R8 compare flag", rd[1], 1);
    wr(4'd9, 16'h0100); rdr(4'd3, rd); check("R10 compare write clears", rd[1], 0);

    // R12 accumulator
    wr(4'd0, 16'h0080); wr(4'd2, 16'h0060); wr(4'd5, 16'h0000);
    pulse_acc(); pulse_acc(); pulse_acc();
    rdr(4'd5, rd); check("R12 edge count", rd, 3);
    rdr(4'd3, rd); check("R12 edge flag", rd[6:5], 2'b10);
    check("R14 irq_acc", irq_acc, 1);
    wr(4'd3, 16'h0040);
    wr(4'd5, 16'hFFFF); pulse_acc();
    rdr(4'd5, rd); check("R12 wrap value", rd, 0);
    rdr(4'd3, rd); check("R12 wrap flag", rd[5], 1);
    wr(4'd0, 16'h0090);
    rdr(4'd5, rd); rdr(4'd3, rd); check("R12 fast clear both", rd[6:5], 0);
    check("R14 irq_acc low", irq_acc, 0);

    finish_run();
  end
endmodule